// File: doc/BRIEF.md
# Inbound Window Address Translator

This block sits behind the BAR decode of a root-port style bridge. It turns the address of an inbound memory or IO request into a 64-bit address on an internal memory bus. Upstream logic supplies a BAR index and a flag that says whether BAR matching is active. From these the block picks one of three translation windows: window 0, window 1, or a catch-all window with index 7. The catch-all window takes every request that matched no BAR, and every request while matching is off.

Each window has a programmed base and a pass-through count. The low `count + 1` bits of the incoming address are copied unchanged. The bits above them come from the base, and the bottom byte of the base is always zero. Requests that are neither memory nor IO leave unchanged and are flagged as untranslated. A small word-wide register port programs the six translation words.

The result passes through a single output register with a valid/ready handshake. The register is controlled by a two-state machine:
- `ST_EMPTY` has nothing to present.
- `ST_FULL` holds one result.

Transitions:
- FILL (`ST_EMPTY` to `ST_FULL`): a request is accepted.
- RELOAD (`ST_FULL` to `ST_FULL`): the result drains and a new request is accepted in the same cycle.
- HOLD (`ST_FULL` to `ST_FULL`): the output is not taken.
- DRAIN (`ST_FULL` to `ST_EMPTY`): the result is taken and no new request arrives.

Top module: `win_xlate_top`

## Requirements
- R1: After reset all eight register addresses read zero and `out_valid` is 0.
- R2: Register word address 2k holds the low word of window k and 2k+1 its high word, where k=0 is window 0, k=1 is window 1 and k=2 is window 7. The low word carries base bits [31:8] in [31:8] and the count in [5:0]. Its bits [7:6] always read 0 and ignore writes. The high word carries base bits [63:32]. Writes to addresses 6 and 7 change nothing, and both addresses read 0.
- R3: With `in_match_en`=1, `in_bar` 0 selects window 0 and `in_bar` 1 selects window 1. Any other `in_bar` value, and every request with `in_match_en`=0, selects window 7. `out_bar` reports the selected window as 0, 1 or 7, including for untranslated requests.
- R4: For a translated request with count c >= 7, output bits [c:0] equal the input bits and the higher bits equal the base (base bits [7:0] being zero).
- R5: A count below 7 acts as 7, so output bits [7:0] always equal input bits [7:0] for translated requests.
- R6: A count of 63 passes all 64 input bits through and the base has no effect.
- R7: `in_kind` 2'b00 (memory) and 2'b01 (IO) are translated with `out_bypass`=0. Kinds 2'b10 and 2'b11 give `out_addr` equal to `in_addr` and `out_bypass`=1.
- R8: An accepted request (`in_valid` and `in_ready` at a rising edge) appears on the outputs after that edge. While `out_valid`=1 and `out_ready`=0, the outputs hold steady and `in_ready`=0. With an empty stage `in_ready`=1.
- R9: A register write in the same cycle as an accepted request does not affect that request's result. It does affect the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with `in_valid` |
| in_addr | input | 64 | Incoming request address |
| in_kind | input | 2 | Request kind: 0 memory, 1 IO, 2/3 other |
| in_bar | input | 3 | BAR index from upstream decode |
| in_match_en | input | 1 | BAR matching active |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with `out_valid` |
| out_addr | output | 64 | Translated (or unchanged) address |
| out_bypass | output | 1 | Request was not translated |
| out_bar | output | 3 | Selected window: 0, 1 or 7 |

## Verification
The bench builds the block with its default parameters: three windows, a 6-bit count with floor 7, and a 3-bit register address. These defaults reach every window, the two unused register addresses, and the full count range, from the floor through 63. With out-of-range BAR indices and matching turned off, all ways into window 7 are exercised. Holding `out_ready` low exercises the HOLD and RELOAD transitions. A write issued in the same cycle as a request shows which result uses the old base.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int ADDR_W  = 64;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 6;
    localparam int BAR_W   = 3;
    localparam int KIND_W  = 2;
    localparam int MID_LO  = 8;
    localparam int MID_W   = WORD_W - MID_LO;
    localparam int MIN_CNT = 7;
    localparam logic [BAR_W-1:0] CATCH_BAR = 3'd7;

    typedef enum logic [KIND_W-1:0] {
        KIND_MEM = 2'd0,
        KIND_IO  = 2'd1,
        KIND_CFG = 2'd2,
        KIND_MSG = 2'd3
    } req_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [MID_W-1:0]  mid;
        logic [CNT_W-1:0]  cnt;
    } win_cfg_t;
endpackage

// File: rtl/xlt_regs.sv
module xlt_regs
    import xlt_pkg::*;
#(
    parameter int NWIN = 3,
    parameter int RAW  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [RAW-1:0]           reg_addr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    output win_cfg_t [NWIN-1:0]      win_o
);
    localparam int WIDX_W = RAW - 1;

    win_cfg_t [NWIN-1:0] win_q;
    logic [WIDX_W-1:0]   widx;

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[k] <= '0;
            end else if (reg_wr && reg_addr == RAW'(2 * k)) begin
                win_q[k].mid <= reg_wdata[WORD_W-1:MID_LO];
                win_q[k].cnt <= reg_wdata[CNT_W-1:0];
            end else if (reg_wr && reg_addr == RAW'(2 * k + 1)) begin
                win_q[k].hi <= reg_wdata;
            end
        end
    end

    assign widx  = reg_addr[RAW-1:1];
    assign win_o = win_q;

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NWIN; k++) begin
            if (int'(widx) == k) begin
                if (reg_addr[0]) reg_rdata = win_q[k].hi;
                else reg_rdata = {win_q[k].mid, {(MID_LO - CNT_W){1'b0}}, win_q[k].cnt};
            end
        end
    end

    // R2: a write to an address outside the windows leaves every window unchanged
    a_r2_unused_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(widx) >= NWIN) |=> $stable(win_q));
endmodule

// File: rtl/xlt_path.sv
module xlt_path
    import xlt_pkg::*;
#(
    parameter int NWIN = 3
) (
    input  win_cfg_t [NWIN-1:0]  win_i,
    input  logic [ADDR_W-1:0]    in_addr,
    input  logic [KIND_W-1:0]    in_kind,
    input  logic [BAR_W-1:0]     in_bar,
    input  logic                 in_match_en,
    output logic [ADDR_W-1:0]    xl_addr,
    output logic                 xl_bypass,
    output logic [BAR_W-1:0]     xl_bar
);
    localparam int SEL_W   = $clog2(NWIN);
    localparam int CATCH   = NWIN - 1;
    localparam int NPASS_W = CNT_W + 1;

    logic [SEL_W-1:0]   sel;
    win_cfg_t           cfg;
    logic [CNT_W-1:0]   cnt_eff;
    logic [NPASS_W-1:0] npass;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  keep;

    always_comb begin
        sel = SEL_W'(CATCH);
        if (in_match_en && int'(in_bar) < CATCH) sel = SEL_W'(in_bar);
    end

    always_comb begin
        cfg = '0;
        for (int k = 0; k < NWIN; k++) begin
            if (int'(sel) == k) cfg = win_i[k];
        end
    end

    assign cnt_eff = (cfg.cnt < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : cfg.cnt;
    assign npass   = NPASS_W'(cnt_eff) + NPASS_W'(1);
    assign base    = {cfg.hi, cfg.mid, {MID_LO{1'b0}}};

    for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
        assign keep[i] = (NPASS_W'(i) < npass);
    end

    assign xl_bypass = !(in_kind == KIND_MEM || in_kind == KIND_IO);
    assign xl_addr   = xl_bypass ? in_addr : ((in_addr & keep) | (base & ~keep));
    assign xl_bar    = (int'(sel) == CATCH) ? CATCH_BAR : BAR_W'(sel);
endmodule

// File: rtl/xlt_stage.sv
module xlt_stage
    import xlt_pkg::*;
#(
    parameter int DW = 68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    stage_state_e state_q, state_d;
    logic [DW-1:0] data_q;
    logic          take;

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (take) data_q <= in_data;
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_data  = data_q;

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r8_fill: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);
    a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/win_xlate_top.sv
module win_xlate_top
    import xlt_pkg::*;
#(
    parameter int NWIN = 3,
    parameter int RAW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [63:0]       in_addr,
    input  logic [1:0]        in_kind,
    input  logic [2:0]        in_bar,
    input  logic              in_match_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_addr,
    output logic              out_bypass,
    output logic [2:0]        out_bar
);
    localparam int DW = ADDR_W + 1 + BAR_W;

    win_cfg_t [NWIN-1:0] win;
    logic [ADDR_W-1:0]   xl_addr;
    logic                xl_bypass;
    logic [BAR_W-1:0]    xl_bar;
    logic [DW-1:0]       st_out;

    xlt_regs #(.NWIN(NWIN), .RAW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_o(win)
    );

    xlt_path #(.NWIN(NWIN)) u_path (
        .win_i(win), .in_addr(in_addr), .in_kind(in_kind), .in_bar(in_bar),
        .in_match_en(in_match_en), .xl_addr(xl_addr), .xl_bypass(xl_bypass),
        .xl_bar(xl_bar)
    );

    xlt_stage #(.DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data({xl_addr, xl_bypass, xl_bar}), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(st_out)
    );

    assign out_addr   = st_out[DW-1:BAR_W+1];
    assign out_bypass = st_out[BAR_W];
    assign out_bar    = st_out[BAR_W-1:0];

    a_r3_bar_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bar == 3'd0 || out_bar == 3'd1 || out_bar == 3'd7));
    a_r3_nomatch_to_catch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_match_en) |=> (out_bar == 3'd7));
    a_r5_low_byte_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind[1] == 1'b0) |=> (out_addr[7:0] == $past(in_addr[7:0]) && !out_bypass));
    a_r7_bypass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind[1] == 1'b1) |=> (out_addr == $past(in_addr) && out_bypass));
    a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_win_xlate_top.sv
module test_win_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_addr = '0;
    logic [1:0]  in_kind = '0;
    logic [2:0]  in_bar = '0;
    logic        in_match_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_addr;
    logic        out_bypass;
    logic [2:0]  out_bar;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] sh [6];
    logic [67:0] expq [$];
    logic [67:0] held;

    always #5 clk = ~clk;

    win_xlate_top i_win_xlate_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .in_kind(in_kind), .in_bar(in_bar),
        .in_match_en(in_match_en), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_bypass(out_bypass), .out_bar(out_bar)
    );

    task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [67:0] model(input logic [63:0] a, input logic [1:0] k,
                                          input logic [2:0] b, input logic m);
        int idx;
        logic [2:0] ob;
        logic [63:0] base, r;
        int c, n;
        idx = 2;
        if (m && b == 3'd0) idx = 0;
        if (m && b == 3'd1) idx = 1;
        ob = (idx == 2) ? 3'd7 : 3'(idx);
        if (k[1]) return {a, 1'b1, ob};
        base = {sh[2*idx+1], sh[2*idx][31:8], 8'h00};
        c = int'(sh[2*idx][5:0]);
        n = ((c < 7) ? 7 : c) + 1;
        for (int i = 0; i < 64; i++) r[i] = (i < n) ? a[i] : base[i];
        return {r, 1'b0, ob};
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) check("R8 unexpected output", {out_addr, out_bypass, out_bar}, '0);
            else check("R4/R7 scoreboard", {out_addr, out_bypass, out_bar}, expq.pop_front());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a < 3'd6) sh[a] = a[0] ? d : (d & 32'hFFFF_FF3F);
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        @(negedge clk);
        reg_addr = a; #1;
        check(tag, {36'd0, reg_rdata}, {36'd0, (a < 3'd6) ? sh[a] : 32'd0});
    endtask

    task automatic send(input logic [63:0] a, input logic [1:0] k, input logic [2:0] b, input logic m);
        @(posedge clk); #1;
        in_valid = 1'b1; in_addr = a; in_kind = k; in_bar = b; in_match_en = m;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        expq.push_back(model(a, k, b, m));
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {67'd0, out_valid}, '0);
        for (int a = 0; a < 8; a++) rd("R1 reset readback", 3'(a));

        // R2 register map, reserved bits, unused addresses
        wr(3'd0, 32'h1234_56CB);   // window 0: count 11, reserved bits set
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd2, 32'hCAFE_0003);   // window 1: count 3 -> floor (R5)
        wr(3'd3, 32'h0000_0001);
        wr(3'd4, 32'h8000_00BF);   // window 7: count 63 (R6)
        wr(3'd5, 32'h5555_5555);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        for (int a = 0; a < 8; a++) rd("R2 readback", 3'(a));

        // R3/R4/R5/R6/R7 traffic, output always ready
        send(64'h0123_4567_89AB_CDEF, 2'd0, 3'd0, 1'b1); // R4 window 0
        send(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3'd1, 1'b1); // R5 window 1 IO
        send(64'h0F0F_F0F0_1234_5678, 2'd0, 3'd5, 1'b1); // R3 other index -> 7, R6
        send(64'h1111_2222_3333_4444, 2'd0, 3'd0, 1'b0); // R3 matching off -> 7
        send(64'hAAAA_BBBB_CCCC_DDDD, 2'd2, 3'd1, 1'b1); // R7 bypass
        send(64'h9999_8888_7777_6666, 2'd3, 3'd0, 1'b1); // R7 bypass
        idle();
        wr(3'd4, 32'hF000_0014);   // window 7 count 20
        send(64'h0000_0000_FFFF_FFFF, 2'd1, 3'd2, 1'b1);
        send(64'h7654_3210_0000_0000, 2'd0, 3'd1, 1'b1);
        idle();

        // R8 latency: empty stage, accept, valid after that edge
        repeat (2) @(posedge clk);
        send(64'h0000_0000_0000_00AB, 2'd0, 3'd0, 1'b1);
        idle();
        check("R8 valid one cycle after accept", {67'd0, out_valid}, {67'd0, 1'b1});
        repeat (2) @(posedge clk);

        // R8 backpressure
        @(posedge clk); #1 out_ready = 1'b0;
        send(64'h0000_1111_0000_2222, 2'd0, 3'd0, 1'b1);
        fork
            send(64'h0000_3333_0000_4444, 2'd1, 3'd1, 1'b1);
            begin
                @(negedge clk);
                held = {out_addr, out_bypass, out_bar};
                repeat (3) begin
                    @(negedge clk);
                    check("R8 held stable", {out_addr, out_bypass, out_bar}, held);
                    check("R8 in_ready low when full", {67'd0, in_ready}, '0);
                end
                @(posedge clk); #1 out_ready = 1'b1;
            end
        join
        idle();
        repeat (3) @(posedge clk);

        // R9 write in the same cycle as an accepted request
        @(posedge clk); #1;
        in_valid = 1'b1; in_addr = 64'h0000_0000_0001_2345; in_kind = 2'd0;
        in_bar = 3'd0; in_match_en = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        check("R9 ready for same-cycle write case", {67'd0, in_ready}, {67'd0, 1'b1});
        expq.push_back(model(64'h0000_0000_0001_2345, 2'd0, 3'd0, 1'b1));
        @(posedge clk); #1;
        reg_wr = 1'b0; in_valid = 1'b0;
        sh[1] = 32'h0BAD_F00D;
        send(64'h0000_0000_0001_2345, 2'd0, 3'd0, 1'b1);
        idle();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 scoreboard drained", {36'd0, 32'(expq.size())}, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule